// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block turns the host's write cycles to a parallel NOR-style flash into the commands that the flash's internal machinery acts on. Each write cycle carries an address and a data byte. The block follows the unlock handshake: a write of AA to address 555, then a write of 55 to address 2AA. It then decodes the command byte that comes after the handshake. For each completed command it raises exactly one single-cycle pulse, in the cycle after the write that completes the command. The commands are program (with its target address and data), chip erase, sector erase (with the sector index), erase suspend, erase resume, autoselect entry and reset.

The block also serves the identifier read path while in autoselect mode. Reads there return a manufacturer code, a device code, or the protection bit of the sector being addressed. A malformed sequence is dropped and the decoder goes back to waiting for a new sequence. While the embedded program or erase engine reports that it is busy, writes are ignored. The one exception is a suspend request during a sector erase. The erase engine, the pin-level bus timing and the protection storage sit outside this block. The engine reports its state back through `op_busy` and `op_sect_erase`.

The write port has no back-pressure. Every cycle with `wr_valid` high is consumed in that cycle, so there is no ready signal. Reads are combinational from `rd_addr`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: An unlock is AA written at an address whose low 11 bits are 555h, followed by 55 written at an address whose low 11 bits are 2AAh. Address bits above bit 10 are ignored for this check.
- R2: Unlock, then A0 at 555h, then one more write: `pgm_pulse` is high for one cycle after that fourth write. `pgm_addr` and `pgm_data` then equal that write's address and data.
- R3: Unlock, then 80 at 555h, then a second unlock, then a sixth write. If the sixth write is 10 at 555h, `chip_erase_pulse` fires. If it is 30 at any address, `sect_erase_pulse` fires and `sect_idx` equals address bits [16:14].
- R4: Unlock, then 90 at 555h, fires `asel_pulse` and sets `rd_asel`. In autoselect, `rd_data` depends on the low byte of `rd_addr`. Offset 00h returns 01h. Offset 01h returns 20h. Offset 02h returns 01h if the sector selected by `rd_addr[16:14]` has its `protect_mask` bit set, and 00h if it does not. Any other offset returns 00h. Outside autoselect, `rd_data` is 00h.
- R5: A reset is F0 written alone at any address, or F0 written right after an unlock. Either form fires `reset_pulse`. Only a reset clears `rd_asel`; other writes in autoselect start no command.
- R6: A wrong address or data byte in the middle of a sequence drops the sequence with no pulse. The following writes are decoded as the start of a new sequence.
- R7: While `op_busy` is high and `op_sect_erase` is low, every write is ignored, F0 included. No pulse fires and no sequence progress is kept.
- R8: B0 written while `op_busy` and `op_sect_erase` are both high fires `susp_pulse` and puts the decoder into the suspended state. B0 at any other time fires nothing.
- R9: In the suspended state (not in autoselect), a lone write of 30 fires `resume_pulse` and leaves the suspended state. A lone 30 outside the suspended state fires nothing.
- R10: In the suspended state, program and autoselect sequences are accepted and the erase setup byte 80 drops the sequence. A reset out of autoselect entered from the suspended state returns the decoder to the suspended state.
- R11: Every command pulse lasts one cycle, and at most one command pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write cycle present this clock |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data byte |
| op_busy | input | 1 | Embedded program or erase is running |
| op_sect_erase | input | 1 | The running operation is a sector erase |
| protect_mask | input | 8 | Protection bit for each sector |
| rd_addr | input | 17 | Read address for identifier reads |
| rd_asel | output | 1 | Read path is in autoselect mode |
| rd_data | output | 8 | Identifier data for rd_addr in autoselect |
| reset_pulse | output | 1 | Reset command decoded |
| pgm_pulse | output | 1 | Program command decoded |
| pgm_addr | output | 17 | Program target address |
| pgm_data | output | 8 | Program data byte |
| chip_erase_pulse | output | 1 | Chip erase command decoded |
| sect_erase_pulse | output | 1 | Sector erase command decoded |
| sect_idx | output | 3 | Sector chosen for sector erase |
| asel_pulse | output | 1 | Autoselect entry decoded |
| susp_pulse | output | 1 | Erase suspend decoded |
| resume_pulse | output | 1 | Erase resume decoded |

## Verification
The bench goes after sequences that break off partway. If a design kept its progress after a bad second cycle, a stray A0 and the next write would turn into a program. It checks that the unlock address uses only the low 11 bits. A full-width compare would reject an unlock at 1D55h. It checks the busy window. A design that let F0 or a new unlock through while busy would fire pulses, and one that kept partial progress across busy would complete a program early. It also checks the round trip from suspended state into autoselect and back. A design that fell back to plain read on that reset would then ignore the resume write, and one that left the suspended state too early would accept 80 or fire on a second 30.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PGM, ST_ERS1, ST_ERS2, ST_ERS3
  } step_e;

  typedef enum logic [1:0] {
    MD_READ, MD_ASEL, MD_SUSP, MD_SUSP_ASEL
  } mode_e;

  typedef enum logic [2:0] {
    EV_NONE, EV_RESET, EV_PGM, EV_CHIP, EV_SECT, EV_ASEL, EV_SUSP, EV_RESUME
  } event_e;

  localparam int          UNL_W     = 11;
  localparam logic [10:0] UNL_ADDR_A = 11'h555;
  localparam logic [10:0] UNL_ADDR_B = 11'h2AA;

  localparam logic [7:0] BYTE_KEY_A   = 8'hAA;
  localparam logic [7:0] BYTE_KEY_B   = 8'h55;
  localparam logic [7:0] BYTE_PROGRAM = 8'hA0;
  localparam logic [7:0] BYTE_ERSETUP = 8'h80;
  localparam logic [7:0] BYTE_IDMODE  = 8'h90;
  localparam logic [7:0] BYTE_RESET   = 8'hF0;
  localparam logic [7:0] BYTE_CHIP    = 8'h10;
  localparam logic [7:0] BYTE_SECTOR  = 8'h30;
  localparam logic [7:0] BYTE_SUSPEND = 8'hB0;
  localparam logic [7:0] BYTE_RESUME  = 8'h30;
endpackage

// File: rtl/fcd_step_fsm.sv
module fcd_step_fsm
  import fcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [UNL_W-1:0] wr_addr_lo,
  input  logic [7:0]       wr_data,
  input  logic             op_busy,
  input  logic             op_sect_erase,
  input  mode_e            mode,
  output event_e           ev
);
  step_e step_q, step_d;
  logic  at_a, at_b, in_asel;

  assign at_a    = (wr_addr_lo == UNL_ADDR_A);
  assign at_b    = (wr_addr_lo == UNL_ADDR_B);
  assign in_asel = (mode == MD_ASEL) || (mode == MD_SUSP_ASEL);

  always_comb begin
    ev     = EV_NONE;
    step_d = step_q;
    if (wr_valid) begin
      if (op_busy) begin
        step_d = ST_IDLE;
        if (op_sect_erase && (wr_data == BYTE_SUSPEND) && (mode == MD_READ))
          ev = EV_SUSP;
      end else begin
        step_d = ST_IDLE;
        unique case (step_q)
          ST_IDLE: begin
            if (wr_data == BYTE_RESET) ev = EV_RESET;
            else if (wr_data == BYTE_KEY_A && at_a) step_d = ST_UNL1;
            else if (wr_data == BYTE_RESUME && mode == MD_SUSP) ev = EV_RESUME;
          end
          ST_UNL1: begin
            if (wr_data == BYTE_RESET) ev = EV_RESET;
            else if (wr_data == BYTE_KEY_B && at_b) step_d = ST_UNL2;
          end
          ST_UNL2: begin
            if (wr_data == BYTE_RESET) ev = EV_RESET;
            else if (at_a && !in_asel) begin
              if (wr_data == BYTE_PROGRAM) step_d = ST_PGM;
              else if (wr_data == BYTE_ERSETUP && mode == MD_READ) step_d = ST_ERS1;
              else if (wr_data == BYTE_IDMODE) ev = EV_ASEL;
            end
          end
          ST_PGM: ev = EV_PGM;
          ST_ERS1: begin
            if (wr_data == BYTE_RESET) ev = EV_RESET;
            else if (wr_data == BYTE_KEY_A && at_a) step_d = ST_ERS2;
          end
          ST_ERS2: begin
            if (wr_data == BYTE_RESET) ev = EV_RESET;
            else if (wr_data == BYTE_KEY_B && at_b) step_d = ST_ERS3;
          end
          ST_ERS3: begin
            if (wr_data == BYTE_RESET) ev = EV_RESET;
            else if (wr_data == BYTE_CHIP && at_a) ev = EV_CHIP;
            else if (wr_data == BYTE_SECTOR) ev = EV_SECT;
          end
          default: step_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step_q <= ST_IDLE;
    else        step_q <= step_d;
  end
endmodule

// File: rtl/fcd_mode_ctl.sv
module fcd_mode_ctl
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  event_e            ev,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output mode_e             mode,
  output logic              reset_pulse,
  output logic              pgm_pulse,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [7:0]        pgm_data,
  output logic              chip_erase_pulse,
  output logic              sect_erase_pulse,
  output logic [SECT_W-1:0] sect_idx,
  output logic              asel_pulse,
  output logic              susp_pulse,
  output logic              resume_pulse
);
  mode_e mode_d;

  always_comb begin
    mode_d = mode;
    unique case (ev)
      EV_RESET:  mode_d = (mode == MD_SUSP_ASEL || mode == MD_SUSP) ? MD_SUSP : MD_READ;
      EV_ASEL:   mode_d = (mode == MD_SUSP) ? MD_SUSP_ASEL : MD_ASEL;
      EV_SUSP:   mode_d = MD_SUSP;
      EV_RESUME: mode_d = MD_READ;
      default:   mode_d = mode;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode             <= MD_READ;
      reset_pulse      <= 1'b0;
      pgm_pulse        <= 1'b0;
      chip_erase_pulse <= 1'b0;
      sect_erase_pulse <= 1'b0;
      asel_pulse       <= 1'b0;
      susp_pulse       <= 1'b0;
      resume_pulse     <= 1'b0;
      pgm_addr         <= '0;
      pgm_data         <= '0;
      sect_idx         <= '0;
    end else begin
      mode             <= mode_d;
      reset_pulse      <= (ev == EV_RESET);
      pgm_pulse        <= (ev == EV_PGM);
      chip_erase_pulse <= (ev == EV_CHIP);
      sect_erase_pulse <= (ev == EV_SECT);
      asel_pulse       <= (ev == EV_ASEL);
      susp_pulse       <= (ev == EV_SUSP);
      resume_pulse     <= (ev == EV_RESUME);
      if (ev == EV_PGM) begin
        pgm_addr <= wr_addr;
        pgm_data <= wr_data;
      end
      if (ev == EV_SECT) sect_idx <= wr_addr[ADDR_W-1 -: SECT_W];
    end
  end
endmodule

// File: rtl/fcd_id_mux.sv
module fcd_id_mux
  import fcd_pkg::*;
#(
  parameter int          SECT_W  = 3,
  parameter logic [7:0]  MFR_ID  = 8'h01,
  parameter logic [7:0]  DEV_ID  = 8'h20,
  localparam int         NSECT   = 1 << SECT_W
) (
  input  mode_e             mode,
  input  logic [7:0]        rd_offset,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic [NSECT-1:0]  protect_mask,
  output logic              rd_asel,
  output logic [7:0]        rd_data
);
  assign rd_asel = (mode == MD_ASEL) || (mode == MD_SUSP_ASEL);

  always_comb begin
    rd_data = 8'h00;
    if (rd_asel) begin
      unique case (rd_offset)
        8'h00:   rd_data = MFR_ID;
        8'h01:   rd_data = DEV_ID;
        8'h02:   rd_data = {7'b0, protect_mask[rd_sect]};
        default: rd_data = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int         ADDR_W = 17,
  parameter int         SECT_W = 3,
  parameter logic [7:0] MFR_ID = 8'h01,
  parameter logic [7:0] DEV_ID = 8'h20,
  localparam int        NSECT  = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              op_busy,
  input  logic              op_sect_erase,
  input  logic [NSECT-1:0]  protect_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_asel,
  output logic [7:0]        rd_data,
  output logic              reset_pulse,
  output logic              pgm_pulse,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [7:0]        pgm_data,
  output logic              chip_erase_pulse,
  output logic              sect_erase_pulse,
  output logic [SECT_W-1:0] sect_idx,
  output logic              asel_pulse,
  output logic              susp_pulse,
  output logic              resume_pulse
);
  event_e ev;
  mode_e  mode;
  logic   unused_rd_mid;

  assign unused_rd_mid = ^rd_addr[ADDR_W-SECT_W-1:8];

  fcd_step_fsm u_step (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_addr_lo(wr_addr[UNL_W-1:0]), .wr_data(wr_data),
    .op_busy(op_busy), .op_sect_erase(op_sect_erase),
    .mode(mode), .ev(ev)
  );

  fcd_mode_ctl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .ev(ev), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .reset_pulse(reset_pulse), .pgm_pulse(pgm_pulse),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .chip_erase_pulse(chip_erase_pulse), .sect_erase_pulse(sect_erase_pulse),
    .sect_idx(sect_idx), .asel_pulse(asel_pulse), .susp_pulse(susp_pulse),
    .resume_pulse(resume_pulse)
  );

  fcd_id_mux #(.SECT_W(SECT_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
    .mode(mode), .rd_offset(rd_addr[7:0]),
    .rd_sect(rd_addr[ADDR_W-1 -: SECT_W]), .protect_mask(protect_mask),
    .rd_asel(rd_asel), .rd_data(rd_data)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              op_busy,
  input logic              op_sect_erase,
  input logic              rd_asel,
  input logic              reset_pulse,
  input logic              pgm_pulse,
  input logic [ADDR_W-1:0] pgm_addr,
  input logic              chip_erase_pulse,
  input logic              sect_erase_pulse,
  input logic              asel_pulse,
  input logic              susp_pulse,
  input logic              resume_pulse
);
  logic [6:0] pulses;
  assign pulses = {reset_pulse, pgm_pulse, chip_erase_pulse, sect_erase_pulse,
                   asel_pulse, susp_pulse, resume_pulse};

  p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));

  p_pgm_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_pulse |-> ($past(wr_valid) && pgm_addr == $past(wr_addr)));

  p_chip_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_pulse |-> ($past(wr_data) == 8'h10 && $past(wr_addr[10:0]) == 11'h555));

  p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && op_busy && !op_sect_erase) |=> (pulses == 7'b0));

  p_susp_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    susp_pulse |-> $past(wr_valid && op_busy && op_sect_erase && wr_data == 8'hB0));

  p_asel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_valid) |-> $stable(rd_asel));
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W)) u_fcd_checker (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .op_busy(op_busy), .op_sect_erase(op_sect_erase),
  .rd_asel(rd_asel), .reset_pulse(reset_pulse), .pgm_pulse(pgm_pulse),
  .pgm_addr(pgm_addr), .chip_erase_pulse(chip_erase_pulse),
  .sect_erase_pulse(sect_erase_pulse), .asel_pulse(asel_pulse),
  .susp_pulse(susp_pulse), .resume_pulse(resume_pulse)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
  localparam logic [6:0] P_NONE = 7'b0000000;
  localparam logic [6:0] P_RST  = 7'b1000000;
  localparam logic [6:0] P_PGM  = 7'b0100000;
  localparam logic [6:0] P_CHIP = 7'b0010000;
  localparam logic [6:0] P_SECT = 7'b0001000;
  localparam logic [6:0] P_ASEL = 7'b0000100;
  localparam logic [6:0] P_SUSP = 7'b0000010;
  localparam logic [6:0] P_RES  = 7'b0000001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        op_busy = 1'b0;
  logic        op_sect_erase = 1'b0;
  logic [7:0]  protect_mask = 8'b0010_0100;
  logic [16:0] rd_addr = '0;
  logic        rd_asel;
  logic [7:0]  rd_data;
  logic        reset_pulse, pgm_pulse, chip_erase_pulse, sect_erase_pulse;
  logic        asel_pulse, susp_pulse, resume_pulse;
  logic [16:0] pgm_addr;
  logic [7:0]  pgm_data;
  logic [2:0]  sect_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_busy(op_busy), .op_sect_erase(op_sect_erase),
    .protect_mask(protect_mask), .rd_addr(rd_addr), .rd_asel(rd_asel),
    .rd_data(rd_data), .reset_pulse(reset_pulse), .pgm_pulse(pgm_pulse),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .chip_erase_pulse(chip_erase_pulse), .sect_erase_pulse(sect_erase_pulse),
    .sect_idx(sect_idx), .asel_pulse(asel_pulse), .susp_pulse(susp_pulse),
    .resume_pulse(resume_pulse)
  );

  function automatic logic [6:0] pulses();
    return {reset_pulse, pgm_pulse, chip_erase_pulse, sect_erase_pulse,
            asel_pulse, susp_pulse, resume_pulse};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One write cycle; on return the pulses caused by it are visible.
  task automatic wr(input logic [16:0] a, input logic [7:0] d,
                    input logic [6:0] exp, input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(pulses() == exp, req, "pulses", 32'(pulses()), 32'(exp));
  endtask

  task automatic unlock(input string req);
    wr(17'h00555, 8'hAA, P_NONE, req);
    wr(17'h002AA, 8'h55, P_NONE, req);
  endtask

  task automatic t_reset_state();
    chk(pulses() == P_NONE, "R11", "pulses after reset", 32'(pulses()), 0);
    chk(rd_asel == 1'b0, "R4", "rd_asel after reset", 32'(rd_asel), 0);
    rd_addr = 17'h00000; #0.1;
    chk(rd_data == 8'h00, "R4", "rd_data outside autoselect", 32'(rd_data), 0);
  endtask

  task automatic t_program();
    wr(17'h01D55, 8'hAA, P_NONE, "R1");
    wr(17'h1E2AA, 8'h55, P_NONE, "R1");
    wr(17'h00555, 8'hA0, P_NONE, "R2");
    wr(17'h12345, 8'h3C, P_PGM, "R2");
    chk(pgm_addr == 17'h12345, "R2", "pgm_addr", 32'(pgm_addr), 32'h12345);
    chk(pgm_data == 8'h3C, "R2", "pgm_data", 32'(pgm_data), 32'h3C);
    @(negedge clk);
    chk(pulses() == P_NONE, "R11", "pulse width", 32'(pulses()), 0);
  endtask

  task automatic t_erase();
    unlock("R3");
    wr(17'h00555, 8'h80, P_NONE, "R3");
    unlock("R3");
    wr(17'h00555, 8'h10, P_CHIP, "R3");
    unlock("R3");
    wr(17'h00555, 8'h80, P_NONE, "R3");
    unlock("R3");
    wr(17'h0C123, 8'h30, P_SECT, "R3");
    chk(sect_idx == 3'd3, "R3", "sect_idx", 32'(sect_idx), 3);
  endtask

  task automatic t_reset_forms();
    unlock("R5");
    wr(17'h00555, 8'hF0, P_RST, "R5");
    wr(17'h1ABCD, 8'hF0, P_RST, "R5");
  endtask

  task automatic t_abort();
    wr(17'h00555, 8'hAA, P_NONE, "R6");
    wr(17'h002AA, 8'h54, P_NONE, "R6");
    wr(17'h00555, 8'hA0, P_NONE, "R6");
    wr(17'h00100, 8'h77, P_NONE, "R6");
    wr(17'h00555, 8'hAA, P_NONE, "R6");
    wr(17'h002AB, 8'h55, P_NONE, "R6");
    wr(17'h00555, 8'hA0, P_NONE, "R6");
    wr(17'h00101, 8'h78, P_NONE, "R6");
    unlock("R6");
    wr(17'h00555, 8'hA0, P_NONE, "R6");
    wr(17'h00102, 8'h79, P_PGM, "R6");
  endtask

  task automatic t_autoselect();
    unlock("R4");
    wr(17'h00555, 8'h90, P_ASEL, "R4");
    chk(rd_asel == 1'b1, "R4", "rd_asel", 32'(rd_asel), 1);
    rd_addr = 17'h1FF00; #0.1;
    chk(rd_data == 8'h01, "R4", "maker code", 32'(rd_data), 1);
    rd_addr = 17'h00201; #0.1;
    chk(rd_data == 8'h20, "R4", "device code", 32'(rd_data), 32'h20);
    rd_addr = 17'h08002; #0.1;
    chk(rd_data == 8'h01, "R4", "sector 2 protected", 32'(rd_data), 1);
    rd_addr = 17'h0C002; #0.1;
    chk(rd_data == 8'h00, "R4", "sector 3 unprotected", 32'(rd_data), 0);
    unlock("R5");
    wr(17'h00555, 8'hA0, P_NONE, "R5");
    wr(17'h00010, 8'h11, P_NONE, "R5");
    chk(rd_asel == 1'b1, "R5", "stays in autoselect", 32'(rd_asel), 1);
    wr(17'h00000, 8'hF0, P_RST, "R5");
    chk(rd_asel == 1'b0, "R5", "autoselect left", 32'(rd_asel), 0);
  endtask

  task automatic t_busy();
    op_busy = 1'b1; op_sect_erase = 1'b0;
    wr(17'h00000, 8'hF0, P_NONE, "R7");
    wr(17'h00000, 8'hB0, P_NONE, "R7");
    unlock("R7");
    wr(17'h00555, 8'hA0, P_NONE, "R7");
    op_busy = 1'b0;
    wr(17'h00300, 8'h5A, P_NONE, "R7");
    unlock("R7");
    wr(17'h00555, 8'hA0, P_NONE, "R7");
    wr(17'h00301, 8'h5B, P_PGM, "R7");
  endtask

  task automatic t_suspend();
    wr(17'h00000, 8'h30, P_NONE, "R9");
    wr(17'h00000, 8'hB0, P_NONE, "R8");
    op_busy = 1'b1; op_sect_erase = 1'b1;
    wr(17'h00555, 8'hAA, P_NONE, "R8");
    wr(17'h00000, 8'hB0, P_SUSP, "R8");
    op_busy = 1'b0; op_sect_erase = 1'b0;
    unlock("R10");
    wr(17'h00555, 8'hA0, P_NONE, "R10");
    wr(17'h14444, 8'hC3, P_PGM, "R10");
    chk(pgm_addr == 17'h14444, "R10", "pgm_addr in suspend", 32'(pgm_addr), 32'h14444);
    unlock("R10");
    wr(17'h00555, 8'h80, P_NONE, "R10");
    unlock("R10");
    wr(17'h00555, 8'h10, P_NONE, "R10");
    unlock("R10");
    wr(17'h00555, 8'h90, P_ASEL, "R10");
    chk(rd_asel == 1'b1, "R10", "autoselect from suspend", 32'(rd_asel), 1);
    wr(17'h00000, 8'h30, P_NONE, "R9");
    wr(17'h00000, 8'hF0, P_RST, "R10");
    chk(rd_asel == 1'b0, "R10", "autoselect left", 32'(rd_asel), 0);
    wr(17'h00000, 8'h30, P_RES, "R9");
    wr(17'h00000, 8'h30, P_NONE, "R9");
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_program();
    t_erase();
    t_reset_forms();
    t_abort();
    t_autoselect();
    t_busy();
    t_suspend();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule